// File: doc/BRIEF.md
# Region-Based Virtual Address Translator

This block turns a 32-bit virtual address into a physical address for a paged memory with 512-byte pages. The two top address bits choose one of three regions. Each region has its own table base register and length register. The program and control regions are reloaded by software on a process switch. The system region is shared by every process. The control region grows downward, so its length test is the reverse of the other two.

A request is first checked against its region's length. Next it is looked up in an eight-entry fully associative translation cache. On a miss, the block reads the table entry through a simple request/acknowledge memory port. It then checks the entry's valid bit and its protection bits, and fills the cache. A write to a page not yet marked modified causes a write-back of the entry with the modify bit set. Each request ends with a one-cycle done pulse that carries the physical address and a fault code. Only one request is handled at a time.

Top module: `vaddr_xlate`

## Requirements
- R1: Address bits 31:30 select the region: 00 program, 01 control, 10 system. Bits 31:30 equal to 11 end the request with fault code 1 and no memory access.
- R2: In the program and system regions, the page index (address bits 29:9) must be less than the region's length register. Otherwise the request ends with fault code 2 and no memory access.
- R3: In the control region, the page index must be greater than or equal to the length register. A smaller index ends with fault code 2 and no memory access.
- R4: A cache miss issues exactly one memory read, at the region base plus four times the page index. Configuration writes select a register with cfg_sel[2:1] (0 program, 1 control, 2 system) and cfg_sel[0] (0 base, 1 length).
- R5: In a table entry, bit 31 is valid, bits 30:27 are protection, bit 26 is modify and bits 20:0 are the frame. A successful request returns fault code 0 and physical address {frame, vaddr[8:0]}. A faulting request returns physical address 0.
- R6: An entry with bit 31 clear ends the request with fault code 3 and is not cached, so a repeat access reads memory again.
- R7: Protection bit 27 allows a user read, bit 28 a user write, bit 29 a kernel read and bit 30 a kernel write. A request whose bit is clear ends with fault code 4.
- R8: A request that hits the translation cache completes without a memory read.
- R9: A write to a page whose modify bit is clear writes the entry back to the same address with bit 26 set, then completes with fault code 0. Later writes to that page issue no write-back.
- R10: A pulse on xb_flush invalidates all program and control region cache entries and keeps system region entries.
- R11: The cache holds 8 translations and replaces them in round-robin order, so the ninth distinct fill evicts the oldest.
- R12: After reset no done pulse and no memory request are present. rsp_done is high for exactly one cycle per request. A request presented while another is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for the base and length registers |
| cfg_sel | input | 3 | Register select: region in bits 2:1, length when bit 0 is set |
| cfg_wdata | input | 32 | Register write data |
| xb_flush | input | 1 | Invalidate process-region cache entries |
| req_valid | input | 1 | Start a translation (accepted only when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for user mode, 0 for kernel mode |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 3 | 0 ok, 1 reserved region, 2 length, 3 not valid, 4 protection |
| rsp_paddr | output | 30 | Physical address |
| mem_req | output | 1 | Table memory request, held until acknowledged |
| mem_we | output | 1 | 1 for an entry write-back |
| mem_addr | output | 32 | Table entry address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Table entry read data |

## Verification
A corrupted cache tag or valid bit shows up at the ports on the next request for that page. Either memory reads appear where a hit was due, or a stale frame number comes back in rsp_paddr two cycles after the request. A wrong round-robin pointer or a flush that hits the wrong entries shows only in later read counts, so the tests count table reads after every access. A wrong cached modify bit shows as a missing or extra write-back during the same request.

// File: rtl/vaddr_xlate.sv
module vaddr_xlate #(
  parameter int XB_N  = 8,
  parameter int OFF_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        xb_flush,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        rsp_done,
  output logic [2:0]  rsp_fault,
  output logic [29:0] rsp_paddr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int IDX_W = 30 - OFF_W;
  localparam int LEN_W = IDX_W + 1;
  localparam int PFN_W = 21;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int PTR_W = (XB_N > 1) ? $clog2(XB_N) : 1;

  localparam logic [2:0] S_IDLE = 3'd0, S_CHECK = 3'd1, S_FETCH = 3'd2,
                         S_EVAL = 3'd3, S_WB = 3'd4;

  logic [2:0]       st;
  logic [31:0]      base_q [3];
  logic [LEN_W-1:0] len_q  [3];
  logic [31:0]      va_q;
  logic             wr_q, usr_q;
  logic [31:0]      pte_q;
  logic [PTR_W-1:0] ptr;

  logic             e_v    [XB_N];
  logic [1:0]       e_reg  [XB_N];
  logic [IDX_W-1:0] e_idx  [XB_N];
  logic [PFN_W-1:0] e_pfn  [XB_N];
  logic [3:0]       e_prot [XB_N];
  logic             e_mod  [XB_N];

  wire [1:0]       reg_id = va_q[31:30];
  wire [IDX_W-1:0] idx    = va_q[29:OFF_W];
  wire [OFF_W-1:0] off    = va_q[OFF_W-1:0];
  wire             rsv    = (reg_id == 2'b11);
  wire [1:0]       reg_c  = rsv ? 2'd0 : reg_id;
  wire [LEN_W-1:0] idx_x  = {1'b0, idx};
  wire             len_bad = (reg_c == 2'd1) ? (idx_x < len_q[reg_c]) : (idx_x >= len_q[reg_c]);

  logic             xb_hit;
  logic [PTR_W-1:0] hit_i;
  always_comb begin
    xb_hit = 1'b0;
    hit_i  = '0;
    for (int i = 0; i < XB_N; i++)
      if (e_v[i] && e_reg[i] == reg_id && e_idx[i] == idx) begin
        xb_hit = 1'b1;
        hit_i  = PTR_W'(i);
      end
  end

  wire [3:0] prot_cur = (st == S_EVAL) ? pte_q[30:27] : e_prot[hit_i];
  wire       mod_cur  = (st == S_EVAL) ? pte_q[26] : e_mod[hit_i];
  wire       prot_ok  = prot_cur[{~usr_q, wr_q}];
  wire       need_wb  = wr_q && !mod_cur;

  logic             fin, go_wb, go_fetch, fill;
  logic [2:0]       code;
  logic [PFN_W-1:0] fin_pfn;
  always_comb begin
    fin = 1'b0; go_wb = 1'b0; go_fetch = 1'b0; fill = 1'b0;
    code = 3'd0;
    fin_pfn = pte_q[PFN_W-1:0];
    case (st)
      S_CHECK: begin
        if (rsv) begin fin = 1'b1; code = 3'd1; end
        else if (len_bad) begin fin = 1'b1; code = 3'd2; end
        else if (xb_hit) begin
          fin_pfn = e_pfn[hit_i];
          if (!prot_ok) begin fin = 1'b1; code = 3'd4; end
          else if (need_wb) go_wb = 1'b1;
          else fin = 1'b1;
        end
        else go_fetch = 1'b1;
      end
      S_EVAL: begin
        if (!pte_q[31]) begin fin = 1'b1; code = 3'd3; end
        else begin
          fill = 1'b1;
          if (!prot_ok) begin fin = 1'b1; code = 3'd4; end
          else if (need_wb) go_wb = 1'b1;
          else fin = 1'b1;
        end
      end
      S_WB: fin = mem_ack;
      default: ;
    endcase
  end

  assign mem_req   = (st == S_FETCH) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = base_q[reg_c] + {{(30 - IDX_W){1'b0}}, idx, 2'b00};
  assign mem_wdata = {pte_q[31:27], 1'b1, pte_q[25:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 3; r++) begin
        base_q[r] <= '0;
        len_q[r]  <= '0;
      end
    end else if (cfg_we && cfg_sel[2:1] != 2'b11) begin
      if (cfg_sel[0]) len_q[cfg_sel[2:1]]  <= cfg_wdata[LEN_W-1:0];
      else            base_q[cfg_sel[2:1]] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rsp_done <= 1'b0;
      rsp_fault <= '0;
      rsp_paddr <= '0;
      va_q <= '0; wr_q <= 1'b0; usr_q <= 1'b0;
      pte_q <= '0;
      ptr <= '0;
      for (int i = 0; i < XB_N; i++) begin
        e_v[i] <= 1'b0; e_reg[i] <= '0; e_idx[i] <= '0;
        e_pfn[i] <= '0; e_prot[i] <= '0; e_mod[i] <= 1'b0;
      end
    end else begin
      rsp_done <= 1'b0;
      if (xb_flush)
        for (int i = 0; i < XB_N; i++)
          if (e_reg[i] != 2'd2) e_v[i] <= 1'b0;

      if (st == S_IDLE && req_valid) begin
        va_q <= req_vaddr; wr_q <= req_write; usr_q <= req_user;
        st <= S_CHECK;
      end
      if (st == S_FETCH && mem_ack) begin
        pte_q <= mem_rdata;
        st <= S_EVAL;
      end
      if (go_fetch) st <= S_FETCH;
      if (go_wb) begin
        st <= S_WB;
        if (st == S_CHECK) begin
          pte_q <= {1'b1, e_prot[hit_i], 1'b0, 5'd0, e_pfn[hit_i]};
          e_mod[hit_i] <= 1'b1;
        end
      end
      if (fill) begin
        e_v[ptr] <= 1'b1; e_reg[ptr] <= reg_id; e_idx[ptr] <= idx;
        e_pfn[ptr] <= pte_q[PFN_W-1:0]; e_prot[ptr] <= pte_q[30:27];
        e_mod[ptr] <= pte_q[26] | (wr_q & prot_ok);
        ptr <= (ptr == PTR_W'(XB_N - 1)) ? '0 : ptr + 1'b1;
      end
      if (fin) begin
        rsp_done  <= 1'b1;
        rsp_fault <= code;
        rsp_paddr <= (code == 3'd0) ? PA_W'({fin_pfn, off}) : '0;
        st <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/vaddr_xlate_chk.sv
module vaddr_xlate_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rsp_done,
  input logic [2:0]      rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [31:0]     mem_addr,
  input logic [2:0]      st,
  input logic            rsv,
  input logic            len_bad,
  input logic            xb_hit
);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !mem_req);

  a_r1_reserved_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && rsv) |=> (rsp_done && rsp_fault == 3'd1 && !mem_req));

  a_r2_length_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && !rsv && len_bad) |=> (rsp_done && rsp_fault == 3'd2 && !mem_req));

  a_r8_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && !rsv && !len_bad && xb_hit) |=> (rsp_done || (mem_req && mem_we)));

  a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault != 3'd0) |-> (rsp_paddr == '0));
endmodule

bind vaddr_xlate vaddr_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .st(st), .rsv(rsv), .len_bad(len_bad), .xb_hit(xb_hit)
);

// File: tb/vaddr_xlate_test.sv
`timescale 1ns/1ps
module vaddr_xlate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_sel = '0; logic [31:0] cfg_wdata = '0;
  logic xb_flush = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic rsp_done; logic [2:0] rsp_fault; logic [29:0] rsp_paddr;
  logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0; logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [31:0] last_addr = '0, last_wdata = '0;
  logic [2:0] last_fault = '0;
  logic [31:0] pmem [0:255];

  vaddr_xlate uut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      last_addr = mem_addr;
      if (mem_we) begin
        wr_cnt++; last_wdata = mem_wdata; pmem[mem_addr[9:2]] = mem_wdata;
      end else begin
        rd_cnt++; mem_rdata = pmem[mem_addr[9:2]];
      end
    end else mem_ack = 1'b0;
    if (rsp_done) begin done_cnt++; last_fault = rsp_fault; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] va(input logic [1:0] r, input logic [20:0] i, input logic [8:0] o);
    return {r, i, o};
  endfunction

  task automatic cfg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input bit w, input bit u,
                     output logic [2:0] f, output logic [29:0] pa);
    bit got = 0;
    @(negedge clk); req_vaddr = a; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    f = 3'd7; pa = '1;
    for (int k = 0; k < 40 && !got; k++) begin
      if (rsp_done) begin got = 1; f = rsp_fault; pa = rsp_paddr; end
      else @(negedge clk);
    end
    @(negedge clk);
    if (!got) begin
      checks++; errors++;
      $display("FAIL R12 no done pulse actual=0 expected=1");
    end
  endtask

  task automatic t_reset;
    chk("R12 reset done", rsp_done, 0);
    chk("R12 reset mem_req", mem_req, 0);
  endtask

  task automatic t_setup;
    for (int i = 0; i < 256; i++) pmem[i] = '0;
    pmem[0] = 32'hF800_0123;
    pmem[1] = 32'h8800_0456;
    pmem[2] = 32'h0000_0789;
    for (int i = 3; i <= 12; i++) pmem[i] = 32'hFC00_0200 + i;
    pmem[8'hF8] = 32'hF800_0AAA;
    pmem[8'hF0] = 32'hF800_0CCC;
    pmem[8'h81] = 32'hF800_0BBB;
    cfg(3'b000, 32'h1000); cfg(3'b001, 16);
    cfg(3'b010, 32'h3000); cfg(3'b011, 32'h1F_FFF0);
    cfg(3'b100, 32'h2200); cfg(3'b101, 4);
  endtask

  task automatic t_miss_hit;
    logic [2:0] f; logic [29:0] pa; int r0 = rd_cnt;
    acc(va(0, 0, 9'h1AB), 0, 1, f, pa);
    chk("R5 miss fault", f, 0);
    chk("R5 miss paddr", pa, {21'h123, 9'h1AB});
    chk("R4 one read", rd_cnt - r0, 1);
    chk("R4 read addr", last_addr, 32'h1000);
    acc(va(0, 0, 9'h005), 0, 1, f, pa);
    chk("R8 hit paddr", pa, {21'h123, 9'h005});
    chk("R8 hit no read", rd_cnt - r0, 1);
  endtask

  task automatic t_modify;
    logic [2:0] f; logic [29:0] pa; int w0 = wr_cnt;
    acc(va(0, 0, 9'h010), 1, 1, f, pa);
    chk("R9 write fault", f, 0);
    chk("R9 writeback count", wr_cnt - w0, 1);
    chk("R9 writeback addr", last_addr, 32'h1000);
    chk("R9 writeback data", last_wdata, 32'hFC00_0123);
    acc(va(0, 0, 9'h011), 1, 1, f, pa);
    chk("R9 no second writeback", wr_cnt - w0, 1);
  endtask

  task automatic t_protect;
    logic [2:0] f; logic [29:0] pa; int r0 = rd_cnt;
    acc(va(0, 1, 9'h020), 1, 1, f, pa);
    chk("R7 user write denied", f, 4);
    chk("R5 fault paddr zero", pa, 0);
    acc(va(0, 1, 9'h021), 0, 1, f, pa);
    chk("R7 user read allowed", pa, {21'h456, 9'h021});
    chk("R7 user read fault", f, 0);
    acc(va(0, 1, 9'h022), 0, 0, f, pa);
    chk("R7 kernel read denied", f, 4);
    chk("R8 protection via cache", rd_cnt - r0, 1);
  endtask

  task automatic t_invalid;
    logic [2:0] f; logic [29:0] pa; int r0 = rd_cnt;
    acc(va(0, 2, 0), 0, 0, f, pa);
    chk("R6 invalid fault", f, 3);
    acc(va(0, 2, 0), 0, 0, f, pa);
    chk("R6 not cached", rd_cnt - r0, 2);
  endtask

  task automatic t_length;
    logic [2:0] f; logic [29:0] pa; int r0 = rd_cnt;
    acc(va(0, 16, 0), 0, 0, f, pa);
    chk("R2 index equals length", f, 2);
    chk("R2 no fetch", rd_cnt - r0, 0);
    acc(va(0, 15, 0), 0, 0, f, pa);
    chk("R2 last page passes", f, 3);
    acc(va(3, 5, 0), 0, 0, f, pa);
    chk("R1 reserved region", f, 1);
    chk("R1 no fetch", rd_cnt - r0, 1);
  endtask

  task automatic t_control;
    logic [2:0] f; logic [29:0] pa; int r0 = rd_cnt;
    acc(va(1, 21'h1F_FFEF, 0), 0, 0, f, pa);
    chk("R3 below length", f, 2);
    chk("R3 no fetch", rd_cnt - r0, 0);
    acc(va(1, 21'h1F_FFF0, 9'h033), 0, 0, f, pa);
    chk("R3 at length", pa, {21'hCCC, 9'h033});
    acc(va(1, 21'h1F_FFF8, 9'h044), 0, 1, f, pa);
    chk("R3 above length", pa, {21'hAAA, 9'h044});
    chk("R4 control addr", last_addr, 32'h0080_2FE0);
  endtask

  task automatic t_system;
    logic [2:0] f; logic [29:0] pa;
    acc(va(2, 1, 9'h0FF), 0, 0, f, pa);
    chk("R1 system paddr", pa, {21'hBBB, 9'h0FF});
    chk("R4 system addr", last_addr, 32'h2204);
    acc(va(2, 4, 0), 0, 0, f, pa);
    chk("R2 system length", f, 2);
  endtask

  task automatic t_flush;
    logic [2:0] f; logic [29:0] pa; int r0;
    @(negedge clk); xb_flush = 1'b1; @(negedge clk); xb_flush = 1'b0;
    r0 = rd_cnt;
    acc(va(2, 1, 0), 0, 0, f, pa);
    chk("R10 system kept", rd_cnt - r0, 0);
    acc(va(0, 0, 0), 0, 0, f, pa);
    chk("R10 program dropped", rd_cnt - r0, 1);
    acc(va(1, 21'h1F_FFF8, 0), 0, 0, f, pa);
    chk("R10 control dropped", rd_cnt - r0, 2);
  endtask

  task automatic t_rr;
    logic [2:0] f; logic [29:0] pa; int r0;
    @(negedge clk); xb_flush = 1'b1; @(negedge clk); xb_flush = 1'b0;
    r0 = rd_cnt;
    for (int p = 3; p <= 10; p++) acc(va(0, 21'(p), 0), 0, 1, f, pa);
    chk("R11 eight fills", rd_cnt - r0, 8);
    acc(va(0, 3, 0), 0, 1, f, pa);
    chk("R11 all eight held", rd_cnt - r0, 8);
    acc(va(0, 11, 0), 0, 1, f, pa);
    acc(va(0, 10, 0), 0, 1, f, pa);
    chk("R11 newest kept", rd_cnt - r0, 9);
    acc(va(0, 3, 7), 0, 1, f, pa);
    chk("R11 oldest evicted", rd_cnt - r0, 10);
    chk("R11 refetch paddr", pa, {21'h203, 9'h007});
  endtask

  task automatic t_busy;
    int d0 = done_cnt;
    @(negedge clk); req_vaddr = va(0, 12, 0); req_write = 0; req_user = 1; req_valid = 1'b1;
    @(negedge clk); req_vaddr = va(3, 0, 0);
    @(negedge clk); req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R12 one done only", done_cnt - d0, 1);
    chk("R12 busy request ignored", last_fault, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_setup;
    t_miss_hit;
    t_modify;
    t_protect;
    t_invalid;
    t_length;
    t_control;
    t_system;
    t_flush;
    t_rr;
    t_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule